// File: doc/BRIEF.md
# Program and Data Memory Access Controller

This block sits between a small 8-bit processor core and its memories. Each request carries an access type, a 16-bit address and, for vector fetches, an interrupt index. The block decides whether the access is served by on-chip ROM or by the external bus. It drives an active-low strobe that tells external logic a data-space access is under way, and it refuses table reads that would expose internal ROM to code running from outside.

Interrupt and reset vectors take up the bottom twelve bytes of program space. Each vector is two bytes, with the high byte at the even address. A vector fetch reads both bytes in turn, assembles the target and loads it into the program-counter output. Reset places address 12 on that output. Only one access is outstanding at a time: the core waits for `req_ready`, and the block answers with a single-cycle `rsp_valid`.

Top module: `mem_access_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it rises, `pc_out` is 12, `req_ready` is 1, `rom_req` and `ext_req` are 0, `dm_n` is 1 and `fault` is 0. Reset in the middle of a vector fetch abandons it. Reset also clears the record of where the last opcode came from, so an internal table read after reset is never blocked.
- R2: The last internal address is 16384·2^s − 1, where s is `cfg_rom_size` and both 2 and 3 mean 64 KB. An access at or below it raises `rom_req`. An access above it raises `ext_req` when `cfg_ext_en` is 1 and faults when it is 0. `mem_addr` carries the request address.
- R3: A refused access issues neither `rom_req` nor `ext_req`. It returns `rsp_data` = 0xFF with `fault` and `rsp_valid` high for one cycle.
- R4: `req_type` encodes 00 opcode fetch, 01 program-table read, 10 data-table read and 11 vector fetch. `dm_n` is low while a data-table read has its memory request raised and `cfg_dm_sel` is 2'b11. In every other case `dm_n` is high.
- R5: `cfg_protect` = 1 blocks a program-table or data-table read whose address is internal, if the most recent completed opcode fetch came from the external bus. The blocked read faults as in R3.
- R6: With `cfg_rom_size` selecting 64 KB, every data-table read faults as in R3.
- R7: A vector fetch with index n from 0 to 5 reads ROM at 2n and then at 2n+1. It then pulses `vec_valid` for one cycle with `vec_addr` = {byte at 2n, byte at 2n+1}, and `pc_out` takes the same value.
- R8: A vector fetch with index 6 or 7 faults as in R3.
- R9: `req_ready` is 0 whenever a memory request is raised. A successful access ends with a single-cycle `rsp_valid` that carries the byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents an access |
| req_ready | output | 1 | Block idle and able to accept |
| req_type | input | 2 | Access type (R4 encoding) |
| req_addr | input | 16 | Access address |
| req_vec_idx | input | 3 | Vector index for vector fetches |
| cfg_rom_size | input | 2 | Internal ROM size strap |
| cfg_ext_en | input | 1 | External bus enabled |
| cfg_protect | input | 1 | ROM protect enabled |
| cfg_dm_sel | input | 2 | Port-mode bits; 2'b11 enables the strobe |
| rom_req | output | 1 | Read request to on-chip ROM |
| ext_req | output | 1 | Read request to the external bus |
| mem_addr | output | 16 | Address for either memory |
| mem_ack | input | 1 | Memory returns data this cycle |
| mem_rdata | input | 8 | Returned byte |
| dm_n | output | 1 | Active-low data-memory strobe |
| rsp_valid | output | 1 | Access complete |
| rsp_data | output | 8 | Byte read, or 0xFF on fault |
| fault | output | 1 | Access refused |
| vec_valid | output | 1 | Assembled vector available |
| vec_addr | output | 16 | Assembled vector |
| pc_out | output | 16 | Program-counter load value |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, 8-bit data, six vectors and a minimum ROM of 16384 bytes. With those values every ROM-size strap gives a boundary that can be reached with a handful of addresses. The routing sweep covers every size strap and both external-enable settings, placing addresses on each side of every boundary. The strobe sweep runs all four port-mode settings against all three non-vector access types. All eight vector indices are fetched, which covers the six legal vectors and both illegal ones.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_PTAB  = 2'b01,
        ACC_DTAB  = 2'b10,
        ACC_VEC   = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_VEC_HI,
        ST_VEC_LO
    } st_e;
endpackage

// File: rtl/mac_decode.sv
module mac_decode #(
    parameter int AW            = 16,
    parameter int VIW           = 3,
    parameter int VEC_COUNT     = 6,
    parameter int ROM_MIN_BYTES = 16384
) (
    input  mac_pkg::acc_e    acc,
    input  logic [AW-1:0]    addr,
    input  logic [VIW-1:0]   vec_idx,
    input  logic [1:0]       rom_size,
    input  logic             ext_en,
    input  logic             protect,
    input  logic             exec_ext,
    output logic             tgt_ext,
    output logic             refuse
);
    import mac_pkg::*;

    localparam logic [AW:0] MIN_SIZE = (AW+1)'(ROM_MIN_BYTES);

    logic [1:0]  size_c;
    logic [AW:0] last_int;
    logic        size_full;
    logic        no_bus;
    logic        prot_hit;

    always_comb begin
        size_c    = rom_size[1] ? 2'd2 : rom_size;
        size_full = rom_size[1];
        last_int  = (MIN_SIZE << size_c) - {{AW{1'b0}}, 1'b1};
        tgt_ext   = {1'b0, addr} > last_int;
        no_bus    = tgt_ext && !ext_en;
        prot_hit  = protect && exec_ext && !tgt_ext;
        unique case (acc)
            ACC_FETCH: refuse = no_bus;
            ACC_PTAB:  refuse = no_bus || prot_hit;
            ACC_DTAB:  refuse = size_full || no_bus || prot_hit;
            default:   refuse = int'(vec_idx) >= VEC_COUNT;
        endcase
    end
endmodule

// File: rtl/mac_strobe.sv
module mac_strobe (
    input  logic       busy_access,
    input  logic       is_data,
    input  logic [1:0] dm_sel,
    output logic       dm_n
);
    logic pin_enabled;

    always_comb begin
        pin_enabled = &dm_sel;
        dm_n        = !(pin_enabled && busy_access && is_data);
    end
endmodule

// File: rtl/mem_access_ctrl.sv
module mem_access_ctrl #(
    parameter int AW            = 16,
    parameter int DW            = 8,
    parameter int VIW           = 3,
    parameter int VEC_COUNT     = 6,
    parameter int ROM_MIN_BYTES = 16384,
    parameter int RESET_PC      = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [1:0]     req_type,
    input  logic [AW-1:0]  req_addr,
    input  logic [VIW-1:0] req_vec_idx,
    input  logic [1:0]     cfg_rom_size,
    input  logic           cfg_ext_en,
    input  logic           cfg_protect,
    input  logic [1:0]     cfg_dm_sel,
    output logic           rom_req,
    output logic           ext_req,
    output logic [AW-1:0]  mem_addr,
    input  logic           mem_ack,
    input  logic [DW-1:0]  mem_rdata,
    output logic           dm_n,
    output logic           rsp_valid,
    output logic [DW-1:0]  rsp_data,
    output logic           fault,
    output logic           vec_valid,
    output logic [AW-1:0]  vec_addr,
    output logic [AW-1:0]  pc_out
);
    import mac_pkg::*;

    typedef struct packed {
        st_e           st;
        logic [AW-1:0] addr;
        logic          tgt_ext;
        logic          is_data;
        logic          is_fetch;
        logic [DW-1:0] hi;
        logic          exec_ext;
        logic          rsp_valid;
        logic [DW-1:0] rsp_data;
        logic          fault;
        logic          vec_valid;
        logic [AW-1:0] vec;
        logic [AW-1:0] pc;
    } regs_t;

    regs_t r_d, r_q;
    acc_e  acc;
    logic  dec_ext;
    logic  dec_refuse;

    assign acc = acc_e'(req_type);

    mac_decode #(
        .AW(AW), .VIW(VIW), .VEC_COUNT(VEC_COUNT), .ROM_MIN_BYTES(ROM_MIN_BYTES)
    ) u_decode (
        .acc      (acc),
        .addr     (req_addr),
        .vec_idx  (req_vec_idx),
        .rom_size (cfg_rom_size),
        .ext_en   (cfg_ext_en),
        .protect  (cfg_protect),
        .exec_ext (r_q.exec_ext),
        .tgt_ext  (dec_ext),
        .refuse   (dec_refuse)
    );

    mac_strobe u_strobe (
        .busy_access (r_q.st == ST_ACCESS),
        .is_data     (r_q.is_data),
        .dm_sel      (cfg_dm_sel),
        .dm_n        (dm_n)
    );

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        r_d.fault     = 1'b0;
        r_d.vec_valid = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (dec_refuse) begin
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_data  = '1;
                        r_d.fault     = 1'b1;
                    end else if (acc == ACC_VEC) begin
                        r_d.st       = ST_VEC_HI;
                        r_d.addr     = AW'({req_vec_idx, 1'b0});
                        r_d.tgt_ext  = 1'b0;
                        r_d.is_data  = 1'b0;
                        r_d.is_fetch = 1'b0;
                    end else begin
                        r_d.st       = ST_ACCESS;
                        r_d.addr     = req_addr;
                        r_d.tgt_ext  = dec_ext;
                        r_d.is_data  = (acc == ACC_DTAB);
                        r_d.is_fetch = (acc == ACC_FETCH);
                    end
                end
            end
            ST_ACCESS: begin
                if (mem_ack) begin
                    r_d.st        = ST_IDLE;
                    r_d.rsp_valid = 1'b1;
                    r_d.rsp_data  = mem_rdata;
                    r_d.is_data   = 1'b0;
                    if (r_q.is_fetch) begin
                        r_d.exec_ext = r_q.tgt_ext;
                    end
                end
            end
            ST_VEC_HI: begin
                if (mem_ack) begin
                    r_d.st      = ST_VEC_LO;
                    r_d.hi      = mem_rdata;
                    r_d.addr[0] = 1'b1;
                end
            end
            default: begin
                if (mem_ack) begin
                    r_d.st        = ST_IDLE;
                    r_d.vec       = AW'({r_q.hi, mem_rdata});
                    r_d.pc        = AW'({r_q.hi, mem_rdata});
                    r_d.vec_valid = 1'b1;
                    r_d.rsp_valid = 1'b1;
                    r_d.rsp_data  = mem_rdata;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
            r_q.pc <= AW'(RESET_PC);
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign rom_req   = ((r_q.st == ST_ACCESS) && !r_q.tgt_ext)
                     || (r_q.st == ST_VEC_HI) || (r_q.st == ST_VEC_LO);
    assign ext_req   = (r_q.st == ST_ACCESS) && r_q.tgt_ext;
    assign mem_addr  = r_q.addr;
    assign rsp_valid = r_q.rsp_valid;
    assign rsp_data  = r_q.rsp_data;
    assign fault     = r_q.fault;
    assign vec_valid = r_q.vec_valid;
    assign vec_addr  = r_q.vec;
    assign pc_out    = r_q.pc;
endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rom_req,
    input logic          ext_req,
    input logic          cfg_ext_en,
    input logic [1:0]    cfg_dm_sel,
    input logic          dm_n,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_data,
    input logic          fault,
    input logic          vec_valid
);
    assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_req && ext_req));

    assert_ext_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> cfg_ext_en);

    assert_fault_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (rsp_valid && rsp_data == {DW{1'b1}} && !rom_req && !ext_req));

    assert_strobe_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dm_n |-> ((rom_req || ext_req) && cfg_dm_sel == 2'b11));

    assert_vec_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(rom_req));

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_req || ext_req) |-> !req_ready);
endmodule

bind mem_access_ctrl mac_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rom_req    (rom_req),
    .ext_req    (ext_req),
    .cfg_ext_en (cfg_ext_en),
    .cfg_dm_sel (cfg_dm_sel),
    .dm_n       (dm_n),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .fault      (fault),
    .vec_valid  (vec_valid)
);

// File: tb/mem_access_ctrl_tb.sv
module mem_access_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_type = 2'b00;
    logic [15:0] req_addr = '0;
    logic [2:0]  req_vec_idx = '0;
    logic [1:0]  cfg_rom_size = 2'd0;
    logic        cfg_ext_en = 1'b0;
    logic        cfg_protect = 1'b0;
    logic [1:0]  cfg_dm_sel = 2'b00;
    logic        rom_req, ext_req, dm_n;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        rsp_valid, fault, vec_valid;
    logic [7:0]  rsp_data;
    logic [15:0] vec_addr, pc_out;

    int checks = 0;
    int errors = 0;

    int          n_rom, n_ext;
    bit          got, dm_low, busy_ready;
    logic [15:0] first_addr;
    logic [7:0]  r_data;
    bit          r_fault, r_vvalid;
    logic [15:0] r_vaddr;

    localparam logic [1:0] T_FETCH = 2'b00, T_PTAB = 2'b01, T_DTAB = 2'b10, T_VEC = 2'b11;

    mem_access_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_type(req_type), .req_addr(req_addr), .req_vec_idx(req_vec_idx),
        .cfg_rom_size(cfg_rom_size), .cfg_ext_en(cfg_ext_en), .cfg_protect(cfg_protect),
        .cfg_dm_sel(cfg_dm_sel), .rom_req(rom_req), .ext_req(ext_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .dm_n(dm_n), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .fault(fault), .vec_valid(vec_valid), .vec_addr(vec_addr),
        .pc_out(pc_out)
    );

    always #5 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic bit is_ext(input logic [1:0] s, input logic [15:0] a);
        int last;
        last = (16384 << ((s == 2'd3) ? 2 : int'(s))) - 1;
        return int'(a) > last;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_req(input logic [1:0] t, input logic [15:0] a, input logic [2:0] vi);
        n_rom = 0; n_ext = 0; got = 0; dm_low = 0; busy_ready = 0; first_addr = '0;
        r_data = '0; r_fault = 0; r_vvalid = 0; r_vaddr = '0;
        @(negedge clk);
        req_valid = 1'b1; req_type = t; req_addr = a; req_vec_idx = vi;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 12 && !got; k++) begin
            if (rsp_valid) begin
                got = 1; r_data = rsp_data; r_fault = fault;
                r_vvalid = vec_valid; r_vaddr = vec_addr;
                mem_ack = 1'b0;
            end else if (rom_req || ext_req) begin
                if (n_rom + n_ext == 0) first_addr = mem_addr;
                if (rom_req) n_rom++; else n_ext++;
                if (!dm_n) dm_low = 1;
                if (req_ready) busy_ready = 1;
                mem_ack = 1'b1;
                mem_rdata = mem_byte(mem_addr);
                @(negedge clk);
            end else begin
                mem_ack = 1'b0;
                @(negedge clk);
            end
        end
        mem_ack = 1'b0;
    endtask

    task automatic expect_fault(input string req);
        chk(got && r_fault, req, "fault flag", int'(r_fault), 1);
        chk(r_data == 8'hFF && n_rom == 0 && n_ext == 0, req, "fault data/no request",
            int'(r_data), 8'hFF);
    endtask

    task automatic expect_ok(input string req, input bit ext, input logic [15:0] a);
        chk(got && !r_fault, req, "no fault", int'(r_fault), 0);
        chk(n_rom == (ext ? 0 : 1) && n_ext == (ext ? 1 : 0), req, "route ext count",
            n_ext, ext ? 1 : 0);
        chk(first_addr == a, req, "mem_addr", int'(first_addr), int'(a));
        chk(r_data == mem_byte(a), req, "read data", int'(r_data), int'(mem_byte(a)));
    endtask

    initial begin
        logic [15:0] alist [8];
        alist = '{16'd12, 16'd16383, 16'd16384, 16'd32767,
                  16'd32768, 16'd65535, 16'h1234, 16'h9ABC};

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(pc_out == 16'd12 && req_ready && !rom_req && !ext_req && dm_n && !fault,
            "R1", "reset outputs pc", int'(pc_out), 12);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pc_out == 16'd12 && req_ready && !rom_req && !ext_req,
            "R1", "after release pc", int'(pc_out), 12);

        // R2, R3: routing sweep over sizes, bus enable and boundary addresses
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 2; e++) begin
                cfg_rom_size = 2'(s); cfg_ext_en = e[0];
                foreach (alist[i]) begin
                    run_req(T_FETCH, alist[i], 3'd0);
                    if (is_ext(2'(s), alist[i]) && e == 0) expect_fault("R3");
                    else expect_ok("R2", is_ext(2'(s), alist[i]), alist[i]);
                end
            end
        end

        // R4: strobe across port modes and access types
        cfg_rom_size = 2'd0; cfg_ext_en = 1'b1; cfg_protect = 1'b0;
        for (int m = 0; m < 4; m++) begin
            cfg_dm_sel = 2'(m);
            for (int t = 0; t < 3; t++) begin
                run_req(2'(t), 16'h5000, 3'd0);
                chk(dm_low == (t == 2 && m == 3), "R4", "strobe low ext", int'(dm_low),
                    int'(t == 2 && m == 3));
                run_req(2'(t), 16'h0100, 3'd0);
                chk(dm_low == (t == 2 && m == 3), "R4", "strobe low int", int'(dm_low),
                    int'(t == 2 && m == 3));
            end
        end
        @(negedge clk);
        chk(dm_n, "R4", "strobe idle", int'(dm_n), 1);
        cfg_dm_sel = 2'b00;

        // R6: 64 KB internal ROM forbids data-table reads
        cfg_rom_size = 2'd2;
        run_req(T_DTAB, 16'h0200, 3'd0); expect_fault("R6");
        cfg_rom_size = 2'd3;
        run_req(T_DTAB, 16'hF000, 3'd0); expect_fault("R6");
        cfg_rom_size = 2'd1;
        run_req(T_DTAB, 16'h0200, 3'd0); expect_ok("R6", 0, 16'h0200);

        // R5: ROM protect
        cfg_rom_size = 2'd0; cfg_protect = 1'b1;
        run_req(T_FETCH, 16'h8000, 3'd0); expect_ok("R5", 1, 16'h8000);
        run_req(T_PTAB, 16'h0200, 3'd0);  expect_fault("R5");
        run_req(T_DTAB, 16'h0300, 3'd0);  expect_fault("R5");
        run_req(T_PTAB, 16'h8100, 3'd0);  expect_ok("R5", 1, 16'h8100);
        cfg_protect = 1'b0;
        run_req(T_PTAB, 16'h0200, 3'd0);  expect_ok("R5", 0, 16'h0200);
        cfg_protect = 1'b1;
        run_req(T_FETCH, 16'h0040, 3'd0); expect_ok("R5", 0, 16'h0040);
        run_req(T_PTAB, 16'h0200, 3'd0);  expect_ok("R5", 0, 16'h0200);

        // R7, R9: vector fetches
        for (int n = 0; n < 6; n++) begin
            logic [15:0] ev;
            ev = {mem_byte(16'(2 * n)), mem_byte(16'(2 * n + 1))};
            run_req(T_VEC, 16'h0000, 3'(n));
            chk(n_rom == 2 && n_ext == 0 && first_addr == 16'(2 * n), "R7", "vector reads",
                int'(first_addr), 2 * n);
            chk(r_vvalid && r_vaddr == ev, "R7", "vec_addr", int'(r_vaddr), int'(ev));
            chk(pc_out == ev, "R7", "pc_out", int'(pc_out), int'(ev));
            chk(!busy_ready, "R9", "ready low while busy", int'(busy_ready), 0);
        end
        @(negedge clk);
        chk(!vec_valid && !rsp_valid, "R9", "one-cycle pulse", int'(vec_valid), 0);

        // R8: out-of-range vector index
        run_req(T_VEC, 16'h0000, 3'd6); expect_fault("R8");
        run_req(T_VEC, 16'h0000, 3'd7); expect_fault("R8");

        // R1: reset in mid vector, and cleared external-execution record
        run_req(T_FETCH, 16'h9000, 3'd0);
        @(negedge clk);
        req_valid = 1'b1; req_type = T_VEC; req_vec_idx = 3'd2;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rom_req && !req_ready, "R1", "vector started", int'(rom_req), 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pc_out == 16'd12 && req_ready && !rom_req && !ext_req, "R1",
            "mid-vector reset pc", int'(pc_out), 12);
        run_req(T_PTAB, 16'h0200, 3'd0); expect_ok("R1", 0, 16'h0200);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule